// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a page table with three levels that lives in word-addressed memory. Pages are 1 KB. The virtual address splits into a 6-bit top index, an 8-bit middle index, an 8-bit bottom index and a 10-bit byte offset. The top table therefore has 64 entries, and the middle and bottom tables have 256 each. A base input gives the frame that holds the top table. Each entry read points to the frame of the next table down. The bottom entry points to the data frame.

A request carries the virtual address and an access kind, and is taken on a valid/ready handshake. `req_ready` is high only while the walker is idle, so the requester stalls until the previous walk has answered. The walker then makes one memory read per level, in strict order, with never more than one read outstanding. It answers with either a physical address or a fault that gives a cause and the level where the walk stopped. The answer is a one-cycle pulse on `rsp_valid` and has no back-pressure; the consumer must take it in that cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0.
- R2: `req_ready` is 1 only while idle. A request is taken on a cycle with `req_valid && req_ready`, and `req_ready` stays 0 from the cycle after acceptance until the response.
- R3: The read address of an entry is the table frame shifted left by 10, plus the level index shifted left by 2. The top index is va[31:26], the middle index is va[25:18] and the bottom index is va[17:10]. The top table frame comes from `ptbr`.
- R4: Reads go out in the order top, middle, bottom. Each is a one-cycle `mem_req` pulse, and the next read waits for `mem_rvalid` of the previous one.
- R5: An entry's bit 0 is valid, bit 1 is write-allowed, bit 2 is execute-allowed, and bits 31:10 are the frame number. Bits 9:3 never change the result.
- R6: An entry with bit 0 clear at any level ends the walk. The response then has `rsp_fault`=1, `rsp_cause`=1 (not present) and `rsp_level` set to the level (0 top, 1 middle, 2 bottom).
- R7: Access code 1 (write) to a valid bottom entry with bit 1 clear gives a fault with `rsp_cause`=2 (protection) and `rsp_level`=2.
- R8: Access code 2 (execute) to a valid bottom entry with bit 2 clear gives a fault with `rsp_cause`=2 and `rsp_level`=2.
- R9: Access codes 0 (read) and 3 need only valid bits. Permission bits in the top and middle entries are ignored.
- R10: A successful walk answers with `rsp_fault`=0, `rsp_cause`=0 and `rsp_pa` equal to the bottom frame followed by va[9:0].
- R11: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, can take a request |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 treated as read |
| ptbr | input | 22 | Frame number of the top table |
| mem_req | output | 1 | One-cycle memory read strobe |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry word |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Walk faulted |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_level | output | 2 | Level that ended the walk |
| rsp_pa | output | 32 | Physical address (zero on fault) |

## Verification
The bench sweeps all 64 top indices, several middle and bottom indices and all four access codes. The memory model builds every entry arithmetically from its own address, so an entry read from the wrong address gives a wrong frame. The validity patterns differ between levels, which places faults at the top, middle and bottom levels and shows whether the reported level is right. The bottom indices cover every combination of the write and execute bits, and the intermediate entries carry noisy permission and reserved bits, which tests that they are ignored. Memory latency depends on the address, which tests that each level waits for its data before moving on.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2, ACC_ALT = 2'd3} acc_e;
  typedef enum logic [1:0] {CS_NONE = 2'd0, CS_ABSENT = 2'd1, CS_PROT = 2'd2} cause_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2} walk_st_e;
  localparam int unsigned BIT_V = 0;
  localparam int unsigned BIT_W = 1;
  localparam int unsigned BIT_X = 2;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned MID_W = 8,
  parameter int unsigned INN_W = 8
) (
  input  logic [VA_W-1:0]       va,
  input  logic [1:0]            level,
  input  logic [VA_W-OFF_W-1:0] frame,
  output logic [VA_W-1:0]       addr
);
  localparam int unsigned TOP_W = VA_W - OFF_W - MID_W - INN_W;
  localparam int unsigned SLT_W = OFF_W - 2;

  logic [SLT_W-1:0] slot;

  always_comb begin
    case (level)
      2'd0:    slot = SLT_W'(va[VA_W-1 -: TOP_W]);
      2'd1:    slot = SLT_W'(va[OFF_W+INN_W +: MID_W]);
      default: slot = SLT_W'(va[OFF_W +: INN_W]);
    endcase
    addr = {frame, slot, 2'b00};
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 10
) (
  input  logic [PTE_W-1:0]       pte,
  input  logic                   last,
  input  logic [1:0]             acc,
  output logic                   fault,
  output logic [1:0]             cause,
  output logic [PTE_W-OFF_W-1:0] frame
);
  always_comb begin
    frame = pte[PTE_W-1:OFF_W];
    fault = 1'b0;
    cause = CS_NONE;
    if (!pte[BIT_V]) begin
      fault = 1'b1;
      cause = CS_ABSENT;
    end else if (last) begin
      if ((acc == ACC_WR && !pte[BIT_W]) || (acc == ACC_EX && !pte[BIT_X])) begin
        fault = 1'b1;
        cause = CS_PROT;
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned MID_W = 8,
  parameter int unsigned INN_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  input  logic [1:0]            req_acc,
  input  logic [VA_W-OFF_W-1:0] ptbr,
  output logic                  mem_req,
  output logic [VA_W-1:0]       mem_addr,
  input  logic                  mem_rvalid,
  input  logic [VA_W-1:0]       mem_rdata,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [1:0]            rsp_cause,
  output logic [1:0]            rsp_level,
  output logic [VA_W-1:0]       rsp_pa
);
  localparam int unsigned FRM_W = VA_W - OFF_W;
  localparam logic [1:0]  LAST_LVL = 2'd2;

  walk_st_e         state;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic [FRM_W-1:0] frame_q;
  logic [1:0]       lvl_q;
  logic             ev_fault;
  logic [1:0]       ev_cause;
  logic [FRM_W-1:0] ev_frame;

  ptw_index_sel #(.VA_W(VA_W), .OFF_W(OFF_W), .MID_W(MID_W), .INN_W(INN_W)) u_sel (
    .va(va_q), .level(lvl_q), .frame(frame_q), .addr(mem_addr)
  );

  ptw_pte_eval #(.PTE_W(VA_W), .OFF_W(OFF_W)) u_eval (
    .pte(mem_rdata), .last(lvl_q == LAST_LVL), .acc(acc_q),
    .fault(ev_fault), .cause(ev_cause), .frame(ev_frame)
  );

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      acc_q     <= '0;
      frame_q   <= '0;
      lvl_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_level <= '0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          acc_q   <= req_acc;
          frame_q <= ptbr;
          lvl_q   <= '0;
          state   <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        default: if (mem_rvalid) begin
          if (ev_fault || lvl_q == LAST_LVL) begin
            rsp_valid <= 1'b1;
            rsp_fault <= ev_fault;
            rsp_cause <= ev_cause;
            rsp_level <= lvl_q;
            rsp_pa    <= ev_fault ? '0 : {ev_frame, va_q[OFF_W-1:0]};
            state     <= ST_IDLE;
          end else begin
            frame_q <= ev_frame;
            lvl_q   <= lvl_q + 2'd1;
            state   <= ST_ISSUE;
          end
        end
      endcase
    end
  end

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !req_ready); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R11
  AST_PROT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == CS_PROT) |-> (rsp_level == LAST_LVL && rsp_fault)); // R7
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == CS_NONE && rsp_level == LAST_LVL)); // R10
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic [21:0] ptbr = 22'h1;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause, rsp_level;
  logic [31:0] rsp_pa;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .ptbr(ptbr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_level(rsp_level), .rsp_pa(rsp_pa)
  );

  // Entry contents are a pure function of the entry address.
  function automatic logic [31:0] pte_at(input logic [31:0] a);
    logic [21:0] fr;
    logic [7:0]  ix;
    logic [5:0]  o;
    logic [7:0]  m;
    fr = a[31:10];
    ix = a[9:2];
    if (a[1:0] != 2'b00) return 32'h0;
    if (fr == 22'h1 && ix < 8'd64) begin
      o = ix[5:0];
      return {22'h100000 | 22'(o), 7'b1010101, o[1], o[0], 1'b1 && (o % 7 != 6)};
    end
    if (fr[21:20] == 2'd1 && fr[19:6] == '0) begin
      m = ix;
      return {22'h200000 | {8'h0, fr[5:0], m}, 7'b1100110, m[0], m[1], 1'b1 && (m % 11 != 10)};
    end
    if (fr[21:20] == 2'd2 && fr[19:14] == '0) begin
      return {({fr[13:8], fr[7:0], ix} ^ 22'h2AAAAA), 7'b0110011, ix[1], ix[0], 1'b1 && (ix % 13 != 12)};
    end
    return 32'h0;
  endfunction

  logic [2:0]  m_cnt;
  logic [31:0] m_data;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_data <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        m_cnt  <= 3'd1 + {1'b0, mem_addr[3:2]};
        m_data <= pte_at(mem_addr);
      end else if (m_cnt != 0) begin
        m_cnt <= m_cnt - 3'd1;
        if (m_cnt == 3'd1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= m_data;
        end
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic walk(input int o, input int m, input int i, input int acc);
    logic [31:0] va;
    logic [9:0]  off;
    bit ov, mv, iv, wb, xb;
    logic        e_fault;
    logic [1:0]  e_cause, e_level;
    logic [31:0] e_pa;
    int w;
    off = 10'((o * 37 + i * 5 + acc) & 32'h3ff);
    va  = {6'(o), 8'(m), 8'(i), off};
    ov = (o % 7) != 6; mv = (m % 11) != 10; iv = (i % 13) != 12;
    wb = i[0]; xb = i[1];
    e_fault = 1'b1; e_cause = 2'd1; e_pa = '0;
    if (!ov) e_level = 2'd0;
    else if (!mv) e_level = 2'd1;
    else begin
      e_level = 2'd2;
      if (!iv) e_cause = 2'd1;                                 // R6
      else if (acc == 1 && !wb) e_cause = 2'd2;                // R7
      else if (acc == 2 && !xb) e_cause = 2'd2;                // R8
      else begin                                               // R9 R10
        e_fault = 1'b0; e_cause = 2'd0;
        e_pa = {({6'(o), 8'(m), 8'(i)} ^ 22'h2AAAAA), off};
      end
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_va = va; req_acc = 2'(acc);
    @(negedge clk);
    req_valid = 1'b0; req_va = ~va;
    check(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
    w = 0;
    while (!rsp_valid && w < 64) begin
      @(negedge clk); w++;
    end
    if (!rsp_valid) begin
      check(1'b0, "R4 walk timeout", 64'd0, 64'd1);
      return;
    end
    check(rsp_fault == e_fault, "R6/R7/R8/R10 fault", 64'(rsp_fault), 64'(e_fault));
    check(rsp_cause == e_cause, "R6/R7/R8 cause", 64'(rsp_cause), 64'(e_cause));
    check(rsp_level == e_level, "R6 level", 64'(rsp_level), 64'(e_level));
    check(rsp_pa == e_pa, "R3 R5 R10 pa", 64'(rsp_pa), 64'(e_pa));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 one-cycle response", 64'(rsp_valid), 64'd0);
  endtask

  int mv_l [3] = '{0, 10, 255};
  int iv_l [7] = '{0, 1, 2, 3, 12, 25, 255};

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 reset state",
          64'({req_ready, rsp_valid, mem_req}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 after reset",
          64'({req_ready, rsp_valid, mem_req}), 64'b100);
    for (int o = 0; o < 64; o++)
      for (int mi = 0; mi < 3; mi++)
        for (int ii = 0; ii < 7; ii++)
          for (int a = 0; a < 4; a++)
            if (!done) walk(o, mv_l[mi], iv_l[ii], a);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule